// File: doc/BRIEF.md
# Speed Ramp With Consist Rate Offset

This block steps a locomotive motor's current speed level toward a commanded target at a programmable pace. The target is given as a coarse speed step in one of three step modes (14, 28 or 128 steps). Internally the block keeps a finer speed level, so in the coarse modes the ramp walks through intermediate levels between steps instead of jumping. A slow external timebase pulse (`tick`) sets the pace. Ramp rates come from a baseline acceleration rate and a baseline braking rate. While consist operation is active, each rate is adjusted by its own signed offset before use.

The outputs are the current fine speed level and a motor duty value. The duty value adds a start-voltage level on top of the speed curve and saturates at full scale. A pulse-width modulator downstream turns the duty value into a drive waveform. The tick period is chosen so that one coarse step takes `rate × 0.896 s / number_of_steps`. With rate 0 the level follows the target within one clock.

Top module: `speed_ramp`

## Requirements
- R1: While `rstN` is low, and after it is released with a zero target, `speedLevel` is 0 and `duty` is 0.
- R2: `stepMode` encoding is 0 = 14 steps, 1 = 28 steps, 2 or 3 = 128 steps. The target is first capped at 14, 28 or 126 for its mode. The fine target is then target×8 in 14-step mode, target×4 in 28-step mode and target×1 in 128-step mode.
- R3: With a nonzero effective rate R, `speedLevel` moves one fine unit toward the fine target every R ticks. A coarse step therefore takes 8R ticks in 14-step mode, 4R in 28-step mode and R in 128-step mode. The level never passes the target.
- R4: When the level rises, the effective acceleration rate sets the pace. When it falls, the effective braking rate sets the pace.
- R5: An offset byte is sign-magnitude: bit 7 set means negative, and bits 6:0 hold the magnitude. The offset is added to its baseline rate only while `consistOn` is 1. Otherwise the baseline is used unchanged.
- R6: An offset sum below 0 gives rate 0. A sum above 255 gives rate 255.
- R7: With an effective rate of 0 in the direction of travel, `speedLevel` equals the fine target one clock after the target is applied, without waiting for a tick.
- R8: With a nonzero target, `duty` = min(255, `startLevel` + 2×`speedLevel`). With a target of 0, `duty` is 0 in the same cycle, whatever the level.
- R9: A new target takes effect at the next tick. The tick counter restarts whenever the direction of travel changes (up, down or holding), so the first step after a reversal comes only after R further ticks.
- R10: With a nonzero rate, the level changes by at most one unit per clock, and only in a cycle where `tick` is high. With no ticks the level stays put.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock timebase pulse that paces the ramp |
| stepMode | input | 2 | Speed-step mode: 0 = 14, 1 = 28, 2/3 = 128 |
| targetStep | input | 8 | Commanded coarse speed step |
| accelBase | input | 8 | Baseline acceleration rate |
| brakeBase | input | 8 | Baseline braking rate |
| accelOffset | input | 8 | Sign-magnitude consist acceleration offset |
| brakeOffset | input | 8 | Sign-magnitude consist braking offset |
| consistOn | input | 1 | Consist mode active; enables the offsets |
| startLevel | input | 8 | Start-voltage level added to the speed curve |
| speedLevel | output | 7 | Current fine speed level |
| duty | output | 8 | Motor duty value, saturated at 255 |

## Verification
A vector table starts each case from reset and tries the ramp in each step mode with different rates and tick counts. Ending levels that differ between modes separate the 8×, 4× and 1× fine scaling. Positive, negative, disabled and clamping offsets each give a different tick count per step. Because of that, dropping the sign, ignoring `consistOn` or wrapping instead of clamping each yields a different final level. Directed cases then ramp downward with a zero acceleration rate to show the braking rate is used, reverse direction mid-count to expose a counter that fails to restart, hold with no ticks, and drop the target to zero to show the duty forced off.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

  typedef enum logic [1:0] {
    MODE_14   = 2'd0,
    MODE_28   = 2'd1,
    MODE_128  = 2'd2,
    MODE_128B = 2'd3
  } stepMode_e;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } rampDir_e;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic snap;
  } rampStrobe_t;

endpackage

// File: rtl/ramp_rate_merge.sv
module ramp_rate_merge #(
  parameter int RATE_W = 8
) (
  input  logic [RATE_W-1:0] base,
  input  logic [RATE_W-1:0] offset,
  input  logic              enable,
  output logic [RATE_W-1:0] rate
);
  localparam int MAG_W = RATE_W - 1;
  localparam int SUM_W = RATE_W + 2;
  localparam logic signed [SUM_W-1:0] RATE_MAX = SUM_W'((1 << RATE_W) - 1);

  logic signed [SUM_W-1:0] baseExt;
  logic signed [SUM_W-1:0] magExt;
  logic signed [SUM_W-1:0] sum;

  always_comb begin
    baseExt = $signed({2'b00, base});
    magExt  = $signed({3'b000, offset[MAG_W-1:0]});
    if (!enable)
      sum = baseExt;
    else if (offset[RATE_W-1])
      sum = baseExt - magExt;
    else
      sum = baseExt + magExt;
    if (sum < 0)
      rate = '0;
    else if (sum > RATE_MAX)
      rate = '1;
    else
      rate = sum[RATE_W-1:0];
  end
endmodule

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import ramp_pkg::*;
#(
  parameter int LVL_W  = 7,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [LVL_W-1:0]  targetFine,
  input  logic [LVL_W-1:0]  level,
  input  logic [RATE_W-1:0] accelRate,
  input  logic [RATE_W-1:0] brakeRate,
  output rampStrobe_t       strobe
);
  rampDir_e          dir;
  rampDir_e          lastDir;
  logic [RATE_W-1:0] rateSel;
  logic [RATE_W-1:0] tickCnt;
  logic              cntDone;

  always_comb begin
    if (targetFine > level)      dir = DIR_UP;
    else if (targetFine < level) dir = DIR_DOWN;
    else                         dir = DIR_HOLD;
    rateSel = (dir == DIR_UP) ? accelRate : brakeRate;
    cntDone = ({1'b0, tickCnt} + 1'b1) >= {1'b0, rateSel};
  end

  always_comb begin
    strobe = '0;
    if (dir != DIR_HOLD) begin
      if (rateSel == '0)
        strobe.snap = 1'b1;
      else if (tick && (dir == lastDir) && cntDone) begin
        strobe.stepUp   = (dir == DIR_UP);
        strobe.stepDown = (dir == DIR_DOWN);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastDir <= DIR_HOLD;
      tickCnt <= '0;
    end else begin
      lastDir <= dir;
      if ((dir != lastDir) || (dir == DIR_HOLD))
        tickCnt <= '0;
      else if (tick)
        tickCnt <= cntDone ? '0 : tickCnt + 1'b1;
    end
  end

  // R10: at most one strobe at a time
  p_onehot_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.stepUp, strobe.stepDown, strobe.snap}));

  // R10: paced steps only happen on a tick
  p_step_on_tick_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepUp || strobe.stepDown) |-> tick);

  // R9: a change of direction restarts the count
  p_restart_on_turn_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dir != lastDir) |=> (tickCnt == '0));

  // R9: no paced step in the cycle the direction changes
  p_no_step_on_turn_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dir != lastDir) |-> !(strobe.stepUp || strobe.stepDown));
endmodule

// File: rtl/ramp_datapath.sv
module ramp_datapath
  import ramp_pkg::*;
#(
  parameter int STEP_W      = 8,
  parameter int LVL_W       = 7,
  parameter int DUTY_W      = 8,
  parameter int TOP_14      = 14,
  parameter int TOP_28      = 28,
  parameter int TOP_128     = 126,
  parameter int FINE_14     = 8,
  parameter int FINE_28     = 4,
  parameter int CURVE_SHIFT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        stepMode,
  input  logic [STEP_W-1:0] targetStep,
  input  logic [DUTY_W-1:0] startLevel,
  input  rampStrobe_t       strobe,
  output logic [LVL_W-1:0]  targetFine,
  output logic [LVL_W-1:0]  level,
  output logic [DUTY_W-1:0] duty
);
  localparam int SUM_W = DUTY_W + 2;
  localparam logic [SUM_W-1:0] DUTY_MAX = SUM_W'((1 << DUTY_W) - 1);

  logic [STEP_W-1:0] capped;
  logic [SUM_W-1:0]  dutySum;

  always_comb begin
    capped     = targetStep;
    targetFine = '0;
    case (stepMode_e'(stepMode))
      MODE_14: begin
        if (targetStep > STEP_W'(TOP_14)) capped = STEP_W'(TOP_14);
        targetFine = LVL_W'(capped) * LVL_W'(FINE_14);
      end
      MODE_28: begin
        if (targetStep > STEP_W'(TOP_28)) capped = STEP_W'(TOP_28);
        targetFine = LVL_W'(capped) * LVL_W'(FINE_28);
      end
      default: begin
        if (targetStep > STEP_W'(TOP_128)) capped = STEP_W'(TOP_128);
        targetFine = LVL_W'(capped);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      level <= '0;
    else if (strobe.snap)
      level <= targetFine;
    else if (strobe.stepUp)
      level <= level + 1'b1;
    else if (strobe.stepDown)
      level <= level - 1'b1;
  end

  always_comb begin
    dutySum = SUM_W'(startLevel) + (SUM_W'(level) << CURVE_SHIFT);
    if (targetStep == '0)
      duty = '0;
    else if (dutySum > DUTY_MAX)
      duty = '1;
    else
      duty = dutySum[DUTY_W-1:0];
  end

  // R3: an upward step never starts at or past the target
  p_no_overshoot_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stepUp |-> (level < targetFine));

  // R7: a snap lands exactly on the fine target
  p_snap_lands_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.snap |=> (level == $past(targetFine)));

  // R10: without a snap the level moves by one unit at most
  p_single_unit_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.snap |=> ((int'(level) - int'($past(level)) <= 1) &&
                      (int'($past(level)) - int'(level) <= 1)));

  // R8: a running duty never drops below the start level
  p_duty_floor_r8: assert property (@(posedge clk) disable iff (!rstN)
    (targetStep != '0) |-> (duty >= startLevel));
endmodule

// File: rtl/speed_ramp.sv
module speed_ramp
  import ramp_pkg::*;
#(
  parameter int STEP_W = 8,
  parameter int LVL_W  = 7,
  parameter int RATE_W = 8,
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [1:0]        stepMode,
  input  logic [STEP_W-1:0] targetStep,
  input  logic [RATE_W-1:0] accelBase,
  input  logic [RATE_W-1:0] brakeBase,
  input  logic [RATE_W-1:0] accelOffset,
  input  logic [RATE_W-1:0] brakeOffset,
  input  logic              consistOn,
  input  logic [DUTY_W-1:0] startLevel,
  output logic [LVL_W-1:0]  speedLevel,
  output logic [DUTY_W-1:0] duty
);
  logic [RATE_W-1:0] accelRate;
  logic [RATE_W-1:0] brakeRate;
  logic [LVL_W-1:0]  targetFine;
  rampStrobe_t       strobe;

  ramp_rate_merge #(.RATE_W(RATE_W)) u_accelMerge (
    .base(accelBase), .offset(accelOffset), .enable(consistOn), .rate(accelRate)
  );

  ramp_rate_merge #(.RATE_W(RATE_W)) u_brakeMerge (
    .base(brakeBase), .offset(brakeOffset), .enable(consistOn), .rate(brakeRate)
  );

  ramp_ctrl #(.LVL_W(LVL_W), .RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .targetFine(targetFine), .level(speedLevel),
    .accelRate(accelRate), .brakeRate(brakeRate),
    .strobe(strobe)
  );

  ramp_datapath #(.STEP_W(STEP_W), .LVL_W(LVL_W), .DUTY_W(DUTY_W)) u_data (
    .clk(clk), .rstN(rstN), .stepMode(stepMode), .targetStep(targetStep),
    .startLevel(startLevel), .strobe(strobe),
    .targetFine(targetFine), .level(speedLevel), .duty(duty)
  );
endmodule

// File: tb/speed_ramp_tb.sv
`timescale 1ns/100ps
module speed_ramp_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic       tick;
  logic [1:0] stepMode;
  logic [7:0] targetStep, accelBase, brakeBase, accelOffset, brakeOffset, startLevel;
  logic       consistOn;
  logic [6:0] speedLevel;
  logic [7:0] duty;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  speed_ramp u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .stepMode(stepMode),
    .targetStep(targetStep), .accelBase(accelBase), .brakeBase(brakeBase),
    .accelOffset(accelOffset), .brakeOffset(brakeOffset), .consistOn(consistOn),
    .startLevel(startLevel), .speedLevel(speedLevel), .duty(duty)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] tgt;
    logic [7:0] accel;
    logic [7:0] brake;
    logic [7:0] aofs;
    logic [7:0] bofs;
    logic       cons;
    logic [7:0] start;
    logic [8:0] ticks;
    logic [6:0] expLvl;
    logic [7:0] expDuty;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{2'd2, 8'd10, 8'd3,   8'd0, 8'h00, 8'h00, 1'b0, 8'd7,  9'd9,   7'd3,   8'd13,  4'd3},  // R3 128-step pacing
    '{2'd1, 8'd2,  8'd2,   8'd0, 8'h00, 8'h00, 1'b0, 8'd7,  9'd10,  7'd5,   8'd17,  4'd3},  // R3 28-step fine units
    '{2'd0, 8'd1,  8'd1,   8'd0, 8'h00, 8'h00, 1'b0, 8'd7,  9'd20,  7'd8,   8'd23,  4'd2},  // R2 14-step x8
    '{2'd2, 8'd50, 8'd5,   8'd0, 8'h83, 8'h00, 1'b1, 8'd0,  9'd8,   7'd4,   8'd8,   4'd5},  // R5 negative offset
    '{2'd2, 8'd50, 8'd5,   8'd0, 8'h83, 8'h00, 1'b0, 8'd0,  9'd8,   7'd1,   8'd2,   4'd5},  // R5 offset disabled
    '{2'd2, 8'd50, 8'd2,   8'd0, 8'h85, 8'h00, 1'b1, 8'd10, 9'd0,   7'd50,  8'd110, 4'd6},  // R6 clamp to 0
    '{2'd2, 8'd50, 8'd250, 8'd0, 8'h7F, 8'h00, 1'b1, 8'd0,  9'd255, 7'd1,   8'd2,   4'd6},  // R6 clamp to 255
    '{2'd1, 8'd28, 8'd0,   8'd0, 8'h00, 8'h00, 1'b0, 8'd40, 9'd0,   7'd112, 8'd255, 4'd8},  // R8 saturation
    '{2'd2, 8'd200,8'd0,   8'd0, 8'h00, 8'h00, 1'b0, 8'd0,  9'd0,   7'd126, 8'd252, 4'd2},  // R2 cap at 126
    '{2'd2, 8'd0,  8'd0,   8'd0, 8'h00, 8'h00, 1'b0, 8'd50, 9'd0,   7'd0,   8'd0,   4'd8},  // R8 zero target
    '{2'd3, 8'd5,  8'd0,   8'd0, 8'h00, 8'h00, 1'b0, 8'd0,  9'd0,   7'd5,   8'd10,  4'd2},  // R2 mode 3 = 128
    '{2'd2, 8'd20, 8'd2,   8'd9, 8'h00, 8'h00, 1'b0, 8'd0,  9'd6,   7'd3,   8'd6,   4'd4}   // R4 rising uses accel
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; tick = 1'b0; stepMode = 2'd2; targetStep = 8'd0;
    accelBase = 8'd0; brakeBase = 8'd0; accelOffset = 8'd0; brakeOffset = 8'd0;
    consistOn = 1'b0; startLevel = 8'd0;
    idle(3);
    chk("R1", "level in reset", int'(speedLevel), 0);
    chk("R1", "duty in reset", int'(duty), 0);
    rstN = 1'b1;
    idle(3);
    chk("R1", "level after reset", int'(speedLevel), 0);
    chk("R1", "duty after reset", int'(duty), 0);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      @(negedge clk) rstN = 1'b0;
      idle(2);
      stepMode = VECS[i].mode; targetStep = VECS[i].tgt;
      accelBase = VECS[i].accel; brakeBase = VECS[i].brake;
      accelOffset = VECS[i].aofs; brakeOffset = VECS[i].bofs;
      consistOn = VECS[i].cons; startLevel = VECS[i].start;
      rstN = 1'b1;
      idle(2);
      pulse_ticks(int'(VECS[i].ticks));
      idle(1);
      chk(tag, "level", int'(speedLevel), int'(VECS[i].expLvl));
      chk(tag, "duty", int'(duty), int'(VECS[i].expDuty));
    end

    // Directed: R7 rate 0 reaches target one clock after it is applied
    @(negedge clk) rstN = 1'b0;
    idle(2);
    stepMode = 2'd2; consistOn = 1'b0; accelOffset = 8'd0; brakeOffset = 8'd0;
    accelBase = 8'd0; brakeBase = 8'd0; startLevel = 8'd0; targetStep = 8'd0;
    rstN = 1'b1;
    idle(2);
    targetStep = 8'd100;
    idle(1);
    chk("R7", "snap after one clock", int'(speedLevel), 100);

    // R4: falling uses braking rate (accel 0 would snap)
    brakeBase = 8'd3; targetStep = 8'd90;
    idle(2);
    pulse_ticks(6);
    idle(1);
    chk("R4", "brake-paced level", int'(speedLevel), 98);
    chk("R8", "duty from level", int'(duty), 196);

    // R9: reversal restarts the tick count
    accelBase = 8'd4; brakeBase = 8'd4; targetStep = 8'd120;
    pulse_ticks(3);
    idle(1);
    chk("R9", "no step before count", int'(speedLevel), 98);
    targetStep = 8'd80;
    pulse_ticks(3);
    idle(1);
    chk("R9", "count restarted after reversal", int'(speedLevel), 98);
    pulse_ticks(1);
    idle(1);
    chk("R9", "step after full count", int'(speedLevel), 97);

    // R10: no ticks, no movement
    accelBase = 8'd2; targetStep = 8'd120;
    idle(40);
    chk("R10", "level held without ticks", int'(speedLevel), 97);

    // R8: zero target forces duty off at once
    startLevel = 8'd30; brakeBase = 8'd5; targetStep = 8'd0;
    #1;
    chk("R8", "duty zero with zero target", int'(duty), 0);
    idle(1);
    chk("R8", "level unchanged without tick", int'(speedLevel), 97);
    targetStep = 8'd120;
    #1;
    chk("R8", "duty with start offset", int'(duty), 224);

    // R3: level stops at target and does not pass it
    accelBase = 8'd1; targetStep = 8'd99;
    idle(2);
    pulse_ticks(6);
    idle(1);
    chk("R3", "stops at target", int'(speedLevel), 99);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule